// File: doc/BRIEF.md
# Daisy-Chain Cascade Position Detector

Each device in a serial daisy chain of codec interfaces carries one copy of this block. When a reset that is sampled on the master clock is released, the block runs two timed measurement windows back to back. Each window lasts a fixed number of master-clock cycles (64 by default). The first window finds the cycle in which the delayed frame-sync from the neighbouring device is first seen high. That cycle index is this device's place in the chain. The second window finds the cycle in which the shared frame-sync line is first seen low. That index is the number of devices at or above this one. The sum of the two indices is the chain length.

The chain master always ends up in the highest slot. A device working alone gets slot 0 and a count of 1. When detection finishes, the block raises a one-cycle done pulse and presents the device count, the slot and a 4-bit device address. The address equals the slot. These outputs then hold until the next reset. A measurement that cannot form a legal chain raises a fault flag. The reason can be a window with no edge, more devices than 4 address bits can name, or a second-window count of zero. While the fault flag is set, the address is forced to 0.

All pins are plain control and status. No data stream passes through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `cascade_pos_detect`

## Requirements
- R1: While `rst_i` is high, and after its release until the done pulse, `done_o`, `fault_o`, `dev_total_o`, `slot_o` and `dev_addr_o` are all 0.
- R2: Edge k (k = 0..63) is the k-th rising clock edge after the first edge at which `rst_i` is sampled low. The first-window count is the smallest k in that range at which `chain_in_i` is sampled high. Later values of `chain_in_i` have no effect.
- R3: Edges 64..127 form the second window, with j = k - 64. The second-window count is the smallest j at which `frame_sync_i` is sampled low. Values of `frame_sync_i` during the first window have no effect.
- R4: `dev_total_o` equals the sum of the first-window count and the second-window count.
- R5: `slot_o` equals the first-window count. When `fault_o` is 0, `dev_addr_o` equals the low 4 bits of that count, so the master of an 8-device chain (count 7) gets address 4'b0111.
- R6: If a window sees no qualifying edge, its count saturates at 64 and `fault_o` is set.
- R7: `fault_o` is also set when the sum exceeds 16 or when the second-window count is 0. Whenever `fault_o` is 1, `dev_addr_o` is 0.
- R8: `done_o` is high for exactly one cycle, following edge 128. The result outputs are valid from that cycle on and hold unchanged until the next reset.
- R9: A reset applied in the middle of a detection abandons it and starts a fresh one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_i | input | 1 | Synchronous reset, active high; detection starts on release |
| chain_in_i | input | 1 | Delayed frame-sync from the neighbouring device |
| frame_sync_i | input | 1 | Shared frame-sync line |
| dev_total_o | output | 8 | Number of devices in the chain |
| slot_o | output | 7 | This device's position (first-window count) |
| dev_addr_o | output | 4 | Assigned device address |
| fault_o | output | 1 | Measurement does not form a legal chain |
| done_o | output | 1 | One-cycle pulse when detection completes |

## Verification
Directed runs place the neighbour's rising edge and the frame-sync falling edge at chosen cycle indices. These cover a lone device, a chain master, a middle slot and the full 16-device chain, and they confirm that both counts are taken independently and then summed. Patterns with no edge in one window, a chain that sums to 17, and a frame-sync that is already low at the start of the second window separate the timeout fault from the range faults. Two more patterns test what must be ignored: a one-cycle pulse on the neighbour line, and frame-sync held low for the whole first window. Together they show that only the first qualifying edge inside its own window counts. Done-pulse timing is checked one cycle before and one cycle after the pulse, result holding is checked several cycles later, and a reset midway through a run shows that detection restarts.

// File: rtl/cpd_pkg.sv
`timescale 1ns/1ps
package cpd_pkg;
  typedef enum logic [1:0] {
    PH_WIN_A = 2'd0,
    PH_WIN_B = 2'd1,
    PH_FIN   = 2'd2,
    PH_HOLD  = 2'd3
  } phase_t;
endpackage

// File: rtl/cpd_phase_seq.sv
`timescale 1ns/1ps
module cpd_phase_seq #(
  parameter int WIN_LEN = 64,
  localparam int IDX_W = $clog2(WIN_LEN)
) (
  input  logic                 clk_i,
  input  logic                 rst_i,
  output logic [IDX_W-1:0]     idx_o,
  output logic                 win_a_o,
  output logic                 win_b_o,
  output logic                 fin_o
);
  import cpd_pkg::*;

  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(WIN_LEN - 1);

  phase_t phase_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      phase_q <= PH_WIN_A;
      idx_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_WIN_A: begin
          if (idx_q == IDX_LAST) begin
            idx_q   <= '0;
            phase_q <= PH_WIN_B;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        PH_WIN_B: begin
          if (idx_q == IDX_LAST) begin
            idx_q   <= '0;
            phase_q <= PH_FIN;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        PH_FIN:  phase_q <= PH_HOLD;
        default: phase_q <= PH_HOLD;
      endcase
    end
  end

  assign idx_o   = idx_q;
  assign win_a_o = (phase_q == PH_WIN_A);
  assign win_b_o = (phase_q == PH_WIN_B);
  assign fin_o   = (phase_q == PH_FIN);

  // R8: the finish phase lasts one cycle, then the block parks
  p_fin_once_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    fin_o |=> (phase_q == PH_HOLD));
  // R3: the second window follows the first one directly
  p_win_order_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    (win_a_o && idx_q == IDX_LAST) |=> (win_b_o && idx_q == '0));
  // R8: once parked, the sequencer stays parked
  p_hold_sticky_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    (phase_q == PH_HOLD) |=> (phase_q == PH_HOLD));
endmodule

// File: rtl/cpd_edge_window.sv
`timescale 1ns/1ps
module cpd_edge_window #(
  parameter int WIN_LEN = 64,
  localparam int IDX_W = $clog2(WIN_LEN),
  localparam int CNT_W = $clog2(WIN_LEN + 1)
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             active_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             evt_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             timeout_o
);
  logic             hit_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      hit_q <= 1'b0;
      cnt_q <= CNT_W'(WIN_LEN);
    end else if (active_i && !hit_q && evt_i) begin
      hit_q <= 1'b1;
      cnt_q <= CNT_W'(idx_i);
    end
  end

  assign cnt_o     = cnt_q;
  assign timeout_o = !hit_q;

  // R6: count never exceeds the saturation value
  p_cnt_bounded_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    cnt_q <= CNT_W'(WIN_LEN));
  // R2: the first capture is final
  p_capture_sticky_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    hit_q |=> (hit_q && $stable(cnt_q)));
  // R6: without a capture the count sits at saturation
  p_sat_idle_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    !hit_q |-> (cnt_q == CNT_W'(WIN_LEN)));
endmodule

// File: rtl/cpd_result.sv
`timescale 1ns/1ps
module cpd_result #(
  parameter int WIN_LEN = 64,
  parameter int ADDR_W  = 4,
  localparam int CNT_W   = $clog2(WIN_LEN + 1),
  localparam int SUM_W   = CNT_W + 1,
  localparam int MAX_DEV = 2 ** ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              fin_i,
  input  logic [CNT_W-1:0]  cnt_a_i,
  input  logic              to_a_i,
  input  logic [CNT_W-1:0]  cnt_b_i,
  input  logic              to_b_i,
  output logic [SUM_W-1:0]  total_o,
  output logic [CNT_W-1:0]  slot_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              fault_o,
  output logic              done_o
);
  logic [SUM_W-1:0] sum_w;
  logic             bad_w;

  always_comb begin
    sum_w = SUM_W'(cnt_a_i) + SUM_W'(cnt_b_i);
    bad_w = to_a_i || to_b_i
         || (sum_w > SUM_W'(MAX_DEV))
         || (cnt_b_i == '0);
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      total_o <= '0;
      slot_o  <= '0;
      addr_o  <= '0;
      fault_o <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      done_o <= fin_i;
      if (fin_i) begin
        total_o <= sum_w;
        slot_o  <= cnt_a_i;
        addr_o  <= bad_w ? '0 : cnt_a_i[ADDR_W-1:0];
        fault_o <= bad_w;
      end
    end
  end

  // R8: done lasts one cycle
  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    done_o |=> !done_o);
  // R8: results only move at the finish cycle
  p_hold_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    !fin_i |=> ($stable(total_o) && $stable(slot_o) && $stable(addr_o) && $stable(fault_o)));
  // R4: a legal chain has the slot strictly below the total
  p_slot_below_total_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    (done_o && !fault_o) |-> (total_o > SUM_W'(slot_o)));
  // R6: a saturated first window is always reported as a fault
  p_sat_faults_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    (done_o && slot_o == CNT_W'(WIN_LEN)) |-> fault_o);
endmodule

// File: rtl/cascade_pos_detect.sv
`timescale 1ns/1ps
module cascade_pos_detect #(
  parameter int WIN_LEN = 64,
  parameter int ADDR_W  = 4,
  localparam int IDX_W  = $clog2(WIN_LEN),
  localparam int CNT_W  = $clog2(WIN_LEN + 1),
  localparam int SUM_W  = CNT_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              chain_in_i,
  input  logic              frame_sync_i,
  output logic [SUM_W-1:0]  dev_total_o,
  output logic [CNT_W-1:0]  slot_o,
  output logic [ADDR_W-1:0] dev_addr_o,
  output logic              fault_o,
  output logic              done_o
);
  logic [IDX_W-1:0] idx;
  logic             win_act [2];
  logic             win_evt [2];
  logic [CNT_W-1:0] win_cnt [2];
  logic             win_to  [2];
  logic             fin;

  cpd_phase_seq #(.WIN_LEN(WIN_LEN)) u_seq (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .idx_o   (idx),
    .win_a_o (win_act[0]),
    .win_b_o (win_act[1]),
    .fin_o   (fin)
  );

  // window 0 waits for the neighbour line to rise, window 1 for frame-sync to fall
  assign win_evt[0] = chain_in_i;
  assign win_evt[1] = !frame_sync_i;

  for (genvar w = 0; w < 2; w++) begin : g_win
    cpd_edge_window #(.WIN_LEN(WIN_LEN)) u_win (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .active_i  (win_act[w]),
      .idx_i     (idx),
      .evt_i     (win_evt[w]),
      .cnt_o     (win_cnt[w]),
      .timeout_o (win_to[w])
    );
  end

  cpd_result #(.WIN_LEN(WIN_LEN), .ADDR_W(ADDR_W)) u_res (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .fin_i   (fin),
    .cnt_a_i (win_cnt[0]),
    .to_a_i  (win_to[0]),
    .cnt_b_i (win_cnt[1]),
    .to_b_i  (win_to[1]),
    .total_o (dev_total_o),
    .slot_o  (slot_o),
    .addr_o  (dev_addr_o),
    .fault_o (fault_o),
    .done_o  (done_o)
  );

  // R7: a faulty result never carries a nonzero address
  p_fault_addr_zero_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    fault_o |-> (dev_addr_o == '0));
  // R1: no completion is reported while the windows are still running
  p_no_early_done_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    (win_act[0] || win_act[1]) |-> !done_o);
endmodule

// File: tb/tb_cascade_pos_detect.sv
`timescale 1ns/1ps
module tb_cascade_pos_detect;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       chain_in = 1'b0;
  logic       fsync = 1'b1;
  logic [7:0] total;
  logic [6:0] slot;
  logic [3:0] addr;
  logic       fault;
  logic       done;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  cascade_pos_detect dut (
    .clk_i        (clk),
    .rst_i        (rst),
    .chain_in_i   (chain_in),
    .frame_sync_i (fsync),
    .dev_total_o  (total),
    .slot_o       (slot),
    .dev_addr_o   (addr),
    .fault_o      (fault),
    .done_o       (done)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    chain_in = 1'b0;
    fsync = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1", "done after reset", int'(done), 0);
    chk("R1", "total after reset", int'(total), 0);
    chk("R1", "addr after reset", int'(addr), 0);
    chk("R1", "fault after reset", int'(fault), 0);
  endtask

  // p1: first-window edge index (64 = none); p2: second-window index (64 = none)
  task automatic run_detect(input string tag, input int p1, input int p2,
                            input bit pulse_a, input bit fs_low_a);
    int exp_tot;
    int exp_fault;
    do_reset();
    for (int i = 0; i < 128; i++) begin
      chain_in = pulse_a ? (i == p1) : (i >= p1);
      if (i < 64) fsync = !fs_low_a;
      else        fsync = !((i - 64) >= p2);
      @(posedge clk);
      @(negedge clk);
      if (i == 100) chk("R1", {tag, " done during window"}, int'(done), 0);
    end
    chk("R8", {tag, " done before final edge"}, int'(done), 0);
    @(posedge clk);
    @(negedge clk);
    exp_tot   = p1 + p2;
    exp_fault = (p1 == 64 || p2 == 64 || exp_tot > 16 || p2 == 0) ? 1 : 0;
    chk("R8", {tag, " done pulse"}, int'(done), 1);
    chk("R4", {tag, " total"}, int'(total), exp_tot);
    chk("R5", {tag, " slot"}, int'(slot), p1);
    chk("R7", {tag, " fault"}, int'(fault), exp_fault);
    chk("R5", {tag, " addr"}, int'(addr), exp_fault ? 0 : (p1 % 16));
    @(posedge clk);
    @(negedge clk);
    chk("R8", {tag, " done drops"}, int'(done), 0);
    chain_in = ~chain_in;
    fsync = ~fsync;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R8", {tag, " total held"}, int'(total), exp_tot);
    chk("R8", {tag, " slot held"}, int'(slot), p1);
    chk("R8", {tag, " done stays low"}, int'(done), 0);
  endtask

  task automatic t_lone();        run_detect("R5 lone", 0, 1, 1'b0, 1'b0); endtask
  task automatic t_master8();     run_detect("R5 master8", 7, 1, 1'b0, 1'b0); endtask
  task automatic t_middle();      run_detect("R2 R3 middle", 3, 5, 1'b0, 1'b0); endtask
  task automatic t_full();        run_detect("R7 full16", 15, 1, 1'b0, 1'b0); endtask
  task automatic t_over();        run_detect("R7 over16", 10, 7, 1'b0, 1'b0); endtask
  task automatic t_to_a();        run_detect("R6 timeout_a", 64, 1, 1'b0, 1'b0); endtask
  task automatic t_to_b();        run_detect("R6 timeout_b", 2, 64, 1'b0, 1'b0); endtask
  task automatic t_zero_b();      run_detect("R7 zero_b", 2, 0, 1'b0, 1'b0); endtask
  task automatic t_ignore();      run_detect("R2 R3 ignore", 4, 3, 1'b1, 1'b1); endtask

  task automatic t_abort();
    // R9: start a run with an early neighbour edge, then reset midway
    do_reset();
    for (int i = 0; i < 40; i++) begin
      chain_in = 1'b1;
      @(posedge clk);
    end
    run_detect("R9 restart", 5, 2, 1'b0, 1'b0);
  endtask

  initial begin
    #1_500_000;
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_lone();
    t_master8();
    t_middle();
    t_full();
    t_over();
    t_to_a();
    t_to_b();
    t_zero_b();
    t_ignore();
    t_abort();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule